// File: doc/BRIEF.md
# RTC Prescaler with Reference Taps

This block sits between a crystal-rate clock enable and the seconds counter of a real-time clock. Each cycle in which the oscillator enable is high advances a binary divider of `DIV_BITS` stages. When the divider wraps, the block emits a one-cycle 1 Hz tick that drives the calendar counters. A stop input freezes the divider so that the time can be set without racing it. A stage-reset command from the register interface zeroes only the upper stages of the divider. This lines up the next second with a software write and leaves the fine phase of the oscillator untouched.

The block also returns a 4-bit reference nibble for readback. It carries a fast square wave taken from a low divider stage (1024 Hz by default), the 1 Hz square wave from the last stage, a minute flag and an hour flag. The two flags are loaded from the carry levels of the external seconds and minutes counters at each tick. A busy output covers a short window of fast-tap periods before each update and the update cycle itself, so the host knows when a digit may be changing under a read. Control and status pins are plain levels or single-cycle pulses. No data stream crosses the block edge, so no handshake applies.

Top module: `rtc_prescaler`

## Requirements
- R1: In reset, and in the first cycle after it, the divider is zero and tick_1hz, ref_nib and busy are all 0.
- R2: Each cycle with osc_en=1 (and stop=0, stage_rst=0) adds one to the divider. The advance that wraps it from all-ones to zero raises tick_1hz for exactly the next cycle.
- R3: While stop=1 the divider holds its value, osc_en has no effect and tick_1hz stays 0.
- R4: A stage_rst pulse clears divider stages RST_LO..DIV_BITS (bit RST_LO-1 up to the MSB). The lower stages keep counting. No tick is produced for that edge, and busy is 0 in the following cycle.
- R5: ref_nib bit 0 is the output of divider stage TAP_STAGE (bit TAP_STAGE-1), a square wave of period 2^TAP_STAGE enables.
- R6: ref_nib bit 1 is the last divider stage (the 1 Hz square wave). It falls in the same cycle that tick_1hz rises.
- R7: At each wrap, ref_nib bit 2 loads sec_wrap and ref_nib bit 3 loads sec_wrap AND min_wrap. Both hold their values between ticks.
- R8: busy is 1 while the count of whole fast-tap periods (divider bits above TAP_STAGE-1) is at least 2^(DIV_BITS-TAP_STAGE) - BUSY_WIN, and also in every cycle where tick_1hz is 1. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | Oscillator-rate enable (32.768 kHz nominal) |
| stop | input | 1 | Freeze divider, suppress tick |
| stage_rst | input | 1 | Clear upper divider stages and busy |
| sec_wrap | input | 1 | Seconds counter at its terminal value |
| min_wrap | input | 1 | Minutes counter at its terminal value |
| tick_1hz | output | 1 | One-cycle pulse per divider wrap |
| ref_nib | output | 4 | {hour flag, minute flag, 1 Hz, fast tap} |
| busy | output | 1 | Update window in progress |

## Verification
The bench builds the block with DIV_BITS=8, TAP_STAGE=2, RST_LO=5 and BUSY_WIN=2, so one "second" takes 256 enables and the fast tap has a period of 4. With these values several wraps fit into a few thousand cycles. Stage resets can land both inside and outside the busy window, and a gapped enable, long stops and minute/hour flag sequences all show up within the run. The parameter constraint BUSY_WIN <= 2^(DIV_BITS-TAP_STAGE-1) holds, so a stage reset always leaves the busy window.

// File: rtl/rtcp_pkg.sv
package rtcp_pkg;
  typedef struct packed {
    logic hour;
    logic minute;
    logic sec;
    logic fast;
  } ref_nib_t;
endpackage

// File: rtl/rtcp_divider.sv
module rtcp_divider #(
  parameter int DIV_BITS = 15,
  parameter int RST_LO   = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  logic                srst,
  output logic [DIV_BITS-1:0] cnt,
  output logic                wrap
);
  localparam int CLR_BIT = RST_LO - 1;

  logic [DIV_BITS-1:0] keep;
  logic [DIV_BITS-1:0] inc;

  for (genvar gi = 0; gi < DIV_BITS; gi++) begin : g_keep
    if (gi >= CLR_BIT) begin : g_hi
      assign keep[gi] = ~srst;
    end else begin : g_lo
      assign keep[gi] = 1'b1;
    end
  end

  assign inc  = cnt + {{(DIV_BITS-1){1'b0}}, adv};
  assign wrap = adv & (&cnt) & ~srst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= inc & keep;
  end
endmodule

// File: rtl/rtcp_taps.sv
module rtcp_taps #(
  parameter int DIV_BITS  = 15,
  parameter int TAP_STAGE = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DIV_BITS-1:0] cnt,
  input  logic                wrap,
  input  logic                sec_wrap,
  input  logic                min_wrap,
  output logic                tick,
  output rtcp_pkg::ref_nib_t  nib
);
  logic min_q, hr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick  <= 1'b0;
      min_q <= 1'b0;
      hr_q  <= 1'b0;
    end else begin
      tick <= wrap;
      if (wrap) begin
        min_q <= sec_wrap;
        hr_q  <= sec_wrap & min_wrap;
      end
    end
  end

  assign nib.hour   = hr_q;
  assign nib.minute = min_q;
  assign nib.sec    = cnt[DIV_BITS-1];
  assign nib.fast   = cnt[TAP_STAGE-1];
endmodule

// File: rtl/rtcp_busy.sv
module rtcp_busy #(
  parameter int DIV_BITS  = 15,
  parameter int TAP_STAGE = 5,
  parameter int BUSY_WIN  = 2
) (
  input  logic [DIV_BITS-1:0] cnt,
  input  logic                tick,
  output logic                busy
);
  localparam int UW  = DIV_BITS - TAP_STAGE;
  localparam int THR = (1 << UW) - BUSY_WIN;

  logic [UW-1:0] periods;
  assign periods = cnt[DIV_BITS-1:TAP_STAGE];

  if (BUSY_WIN == 0) begin : g_none
    assign busy = tick;
  end else begin : g_win
    assign busy = tick | (int'(periods) >= THR);
  end
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_BITS  = 15,
  parameter int TAP_STAGE = 5,
  parameter int RST_LO    = 11,
  parameter int BUSY_WIN  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en,
  input  logic       stop,
  input  logic       stage_rst,
  input  logic       sec_wrap,
  input  logic       min_wrap,
  output logic       tick_1hz,
  output logic [3:0] ref_nib,
  output logic       busy
);
  logic [DIV_BITS-1:0] cnt;
  logic                wrap;
  logic                adv;
  rtcp_pkg::ref_nib_t  nib;

  assign adv = osc_en & ~stop;

  rtcp_divider #(.DIV_BITS(DIV_BITS), .RST_LO(RST_LO)) u_div (
    .clk(clk), .rst_n(rst_n), .adv(adv), .srst(stage_rst),
    .cnt(cnt), .wrap(wrap)
  );

  rtcp_taps #(.DIV_BITS(DIV_BITS), .TAP_STAGE(TAP_STAGE)) u_taps (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .wrap(wrap),
    .sec_wrap(sec_wrap), .min_wrap(min_wrap),
    .tick(tick_1hz), .nib(nib)
  );

  rtcp_busy #(.DIV_BITS(DIV_BITS), .TAP_STAGE(TAP_STAGE), .BUSY_WIN(BUSY_WIN)) u_busy (
    .cnt(cnt), .tick(tick_1hz), .busy(busy)
  );

  assign ref_nib = nib;
endmodule

// File: rtl/rtc_prescaler_chk.sv
module rtc_prescaler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stop,
  input logic       stage_rst,
  input logic       tick_1hz,
  input logic [3:0] ref_nib,
  input logic       busy
);
  a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz |=> !tick_1hz);
  a_r3_no_tick_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !tick_1hz);
  a_r3_hold_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !stage_rst) |=> $stable(ref_nib[1:0]));
  a_r4_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stage_rst |=> (!busy && !ref_nib[1] && !tick_1hz));
  a_r6_sec_falls: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz |-> $fell(ref_nib[1]));
  a_r7_flags_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_nib[3:2]) |-> tick_1hz);
  a_r7_hour_needs_min: assert property (@(posedge clk) disable iff (!rst_n)
    ref_nib[3] |-> ref_nib[2]);
  a_r8_busy_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz |-> busy);
endmodule

bind rtc_prescaler rtc_prescaler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stop(stop), .stage_rst(stage_rst),
  .tick_1hz(tick_1hz), .ref_nib(ref_nib), .busy(busy)
);

// File: tb/sim_rtc_prescaler.sv
module sim_rtc_prescaler;
  localparam int CLK_NS = 10;
  localparam int DIVB   = 8;
  localparam int TAP    = 2;
  localparam int RLO    = 5;
  localparam int WIN    = 2;
  localparam int MAXC   = (1 << DIVB) - 1;
  localparam int LOMASK = (1 << (RLO - 1)) - 1;
  localparam int THR    = (1 << (DIVB - TAP)) - WIN;

  logic clk = 1'b0, rst_n = 1'b0;
  logic osc_en = 0, stop = 0, stage_rst = 0, sec_wrap = 0, min_wrap = 0;
  logic tick_1hz, busy;
  logic [3:0] ref_nib;

  int n_chk = 0, n_fail = 0;
  int m_cnt = 0;
  bit m_tick = 0, m_min = 0, m_hr = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  rtc_prescaler #(.DIV_BITS(DIVB), .TAP_STAGE(TAP), .RST_LO(RLO), .BUSY_WIN(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .stop(stop), .stage_rst(stage_rst),
    .sec_wrap(sec_wrap), .min_wrap(min_wrap),
    .tick_1hz(tick_1hz), .ref_nib(ref_nib), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit eb;
    eb = ((m_cnt >> TAP) >= THR) || m_tick;
    check(tick_1hz == m_tick, "R2 tick", tick_1hz, m_tick);
    check(ref_nib[0] == m_cnt[TAP-1], "R5 fast tap", ref_nib[0], m_cnt[TAP-1]);
    check(ref_nib[1] == m_cnt[DIVB-1], "R6 1Hz tap", ref_nib[1], m_cnt[DIVB-1]);
    check(ref_nib[3:2] == {m_hr, m_min}, "R7 flags", ref_nib[3:2], {m_hr, m_min});
    check(busy == eb, "R8 busy", busy, eb);
  endtask

  task automatic cyc(input bit o, input bit s, input bit r, input bit sw, input bit mw);
    bit adv, wr;
    osc_en = o; stop = s; stage_rst = r; sec_wrap = sw; min_wrap = mw;
    @(posedge clk);
    adv = o && !s;
    wr  = adv && (m_cnt == MAXC) && !r;
    m_cnt = (m_cnt + int'(adv)) & MAXC;
    if (r) m_cnt = m_cnt & LOMASK;
    m_tick = wr;
    if (wr) begin m_min = sw; m_hr = sw && mw; end
    #1;
    compare_all();
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    check(tick_1hz == 0 && ref_nib == 0 && busy == 0, "R1 in reset",
          {tick_1hz, ref_nib, busy}, 0);
    rst_n = 1;
    m_cnt = 0; m_tick = 0; m_min = 0; m_hr = 0;
    cyc(0, 0, 0, 0, 0);
    check(ref_nib == 0 && busy == 0 && tick_1hz == 0, "R1 after reset",
          {tick_1hz, ref_nib, busy}, 0);
  endtask

  task automatic t_count();
    int ticks = 0;
    for (int i = 0; i < 600; i++) begin
      cyc(1, 0, 0, 0, 0);
      if (tick_1hz) ticks++;
    end
    check(ticks == 2, "R2 ticks in 600 enables", ticks, 2);
  endtask

  task automatic t_gapped();
    int ticks = 0;
    for (int i = 0; i < 800; i++) begin
      cyc((i % 3) == 0, 0, 0, 0, 0);
      if (tick_1hz) ticks++;
    end
    check(ticks >= 1, "R2 gapped enable ticks", ticks, 1);
  endtask

  task automatic t_stop();
    logic [3:0] held;
    held = ref_nib;
    for (int i = 0; i < 30; i++) begin
      cyc(1, 1, 0, 0, 0);
      check(ref_nib[1:0] == held[1:0] && !tick_1hz, "R3 stop holds",
            ref_nib[1:0], held[1:0]);
    end
    while (m_cnt != MAXC) cyc(1, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0);
    check(!tick_1hz, "R3 stop on wrap edge", tick_1hz, 0);
    cyc(1, 0, 0, 0, 0);
    check(tick_1hz == 1, "R2 wrap after stop", tick_1hz, 1);
  endtask

  task automatic t_stage_rst();
    while (m_cnt != 8'hA6) cyc(1, 0, 0, 0, 0);
    cyc(1, 0, 1, 0, 0);
    check(!busy && !ref_nib[1], "R4 clear mid count", {busy, ref_nib[1]}, 0);
    while (!busy) cyc(1, 0, 0, 0, 0);
    cyc(1, 0, 1, 0, 0);
    check(!busy, "R4 clears busy", busy, 0);
    while (m_cnt != MAXC) cyc(1, 0, 0, 0, 0);
    cyc(1, 0, 1, 0, 0);
    check(!tick_1hz && !busy, "R4 no tick on reset edge", tick_1hz, 0);
    cyc(1, 1, 1, 0, 0);
    check(!busy, "R4 with stop", busy, 0);
  endtask

  task automatic t_flags();
    bit sw_seq[4] = '{1, 1, 0, 1};
    bit mw_seq[4] = '{0, 1, 1, 1};
    for (int k = 0; k < 4; k++) begin
      while (m_cnt != MAXC) cyc(1, 0, 0, k[0], ~k[0]);
      cyc(1, 0, 0, sw_seq[k], mw_seq[k]);
      check(ref_nib[2] == sw_seq[k], "R7 minute flag", ref_nib[2], sw_seq[k]);
      check(ref_nib[3] == (sw_seq[k] & mw_seq[k]), "R7 hour flag",
            ref_nib[3], sw_seq[k] & mw_seq[k]);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_count();
    t_gapped();
    t_stop();
    t_stage_rst();
    t_flags();
    t_reset();
    done = 1;
    finish_run();
  end
endmodule